// File: doc/BRIEF.md
# Last-Result and Last-Load Operand Forwarding Control

This block decides, for every source operand of the instruction that decode presents, where the operand comes from. There are three possible sources: the normal register-file read path, the last-result latch, or the last-load latch. The last-result latch holds the output of the previous ALU operation. The last-load latch holds whatever data most recently came back from memory. The block handles control only. It tracks which register each latch stands for and whether that copy may still be trusted. The datapath multiplexers, the register file with its interlock, and the ALU live elsewhere and act on the per-operand select code this block produces.

The two paths keep validity in different ways. A last result serves exactly one consumer: the next instruction that decode accepts. It is only offered when the producer was an unconditional data-processing instruction that writes a register. A last-load value can serve any number of later instructions. It stays valid until a newer load returns, or until something else writes its register. A small saturating counter tracks loads that have been issued but have not yet returned. A consumer that matches the last-load register while loads are still in flight is held back with a stall, because the value in the latch might not be the newest one.

Decode hands instructions over with a valid/ready handshake. Ready drops whenever any used operand has to wait for the outstanding loads to drain. While ready is low, decode must hold the instruction and its fields steady, and the block records nothing from it. The load-issue event also uses a valid/ready handshake. Its ready is low while the counter is full, and an issue offered in that state is not counted. Load returns and ALU write-backs are plain one-cycle event strobes that cannot be refused.

Top module: `fwd_ctrl`

## Requirements
- R1: An accepted instruction of class data-processing (code 0) or load (code 1) gets select code 1 (last result) on each used operand whose register equals the destination of the previously accepted instruction. This applies only if that producer was class 0, had its write flag set and carried condition code 4'hE. Operand k's select sits in op_sel[2k+1:2k].
- R2: A recorded last result serves only the next accepted instruction. Cycles without an accepted instruction leave it in place. Once any other instruction is accepted, a later match gets code 0.
- R3: A producer with any condition code other than 4'hE, with its write flag clear, or of a class other than 0 never leads to code 1.
- R4: An operand whose use flag is clear, or any operand of a store (class 2) or other (class 3) instruction, gets code 0 and no stall.
- R5: A load return records its register in the last-load latch. A used operand of a class 0 or 1 instruction that matches that register, with no last-result match and zero loads outstanding, gets code 2. This holds for every later instruction until the value is invalidated.
- R6: When such a last-load match occurs while the outstanding-load count is nonzero, that operand raises its stall bit with code 0, dec_ready is low, and nothing is recorded from that instruction.
- R7: The last-load value is invalidated by an accepted non-load instruction with its write flag set to the same register, or by an ALU write-back to that register. If such a write names the register of a load returning in the same cycle, the new value starts out invalid.
- R8: The outstanding-load count is 3 bits wide. It saturates at 7, and ld_issue_ready is low at 7. A return at count 0 is ignored. An accepted issue and a return in the same cycle leave the count unchanged.
- R9: With cfg_lr_en low, code 1 is never produced. With cfg_ll_en low, code 2 and the stall bits are never produced.
- R10: When both paths match the same operand, the last-result path wins.
- R11: After reset, no latch is valid, the count is zero and ld_issue_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lr_en | input | 1 | Enable for the last-result path |
| cfg_ll_en | input | 1 | Enable for the last-load path |
| dec_valid | input | 1 | Decode presents an instruction |
| dec_ready | output | 1 | Instruction accepted this cycle when valid |
| dec_cls | input | 2 | Class: 0 data-processing, 1 load, 2 store, 3 other |
| dec_cond | input | 4 | Condition field, 4'hE means always |
| dec_wr | input | 1 | Instruction writes its destination |
| dec_dst | input | 4 | Destination register |
| dec_src | input | 8 | Operand registers, operand k at [4k+3:4k] |
| dec_src_use | input | 2 | Operand k is read |
| op_sel | output | 4 | Per-operand source: 0 register file, 1 last result, 2 last load |
| op_stall | output | 2 | Per-operand wait on outstanding loads |
| ld_issue_valid | input | 1 | A load is being issued |
| ld_issue_ready | output | 1 | Counter can take another issue |
| ld_ret_valid | input | 1 | Load data returned this cycle |
| ld_ret_reg | input | 4 | Register the returned data is for |
| alu_wb_valid | input | 1 | ALU write-back this cycle |
| alu_wb_reg | input | 4 | Register of that write-back |

## Verification
The hardest state to reach from the ports is a last-result match and a valid last-load match on the same register at the same time. This state is needed to see which path wins. Any accepted producer writing that register also invalidates the last-load copy, so the bench accepts the producer, leaves decode idle for one cycle while a load returns for that same register, and then presents the consumer. The bench also fills the counter to saturation with back-to-back issues. It pairs an issue with a return in the same cycle, and it times a kill to coincide with a return. It sweeps every pair of producer destination and consumer operand, and every condition code.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic [1:0] {
    CLS_DP    = 2'd0,
    CLS_LOAD  = 2'd1,
    CLS_STORE = 2'd2,
    CLS_OTHER = 2'd3
  } op_class_e;

  typedef enum logic [1:0] {
    SRC_RF = 2'd0,
    SRC_LR = 2'd1,
    SRC_LL = 2'd2
  } src_sel_e;

  localparam logic [3:0] COND_ALWAYS = 4'hE;

  function automatic logic class_can_forward(input logic [1:0] cls);
    return (cls == CLS_DP) || (cls == CLS_LOAD);
  endfunction

endpackage

// File: rtl/fwd_lr_track.sv
module fwd_lr_track
  import fwd_pkg::*;
#(
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic [1:0]    cls,
  input  logic [3:0]    cond,
  input  logic          wr,
  input  logic [RW-1:0] dst,
  output logic          lr_valid,
  output logic [RW-1:0] lr_dest
);

  logic produces;

  always_comb begin
    produces = wr && (cls == CLS_DP) && (cond == COND_ALWAYS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_valid <= 1'b0;
      lr_dest  <= '0;
    end else if (acc) begin
      lr_valid <= produces;
      lr_dest  <= dst;
    end
  end

endmodule

// File: rtl/fwd_ll_track.sv
module fwd_ll_track #(
  parameter int RW    = 4,
  parameter int CW    = 3,
  parameter int NKILL = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_issue_valid,
  output logic              ld_issue_ready,
  input  logic              ld_ret_valid,
  input  logic [RW-1:0]     ld_ret_reg,
  input  logic [NKILL-1:0]  kill_v,
  input  logic [NKILL*RW-1:0] kill_reg,
  output logic              ll_valid,
  output logic [RW-1:0]     ll_reg,
  output logic              cnt_zero,
  output logic [CW-1:0]     cnt
);

  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic             inc, dec;
  logic [NKILL-1:0] hit_ret, hit_cur;

  assign ld_issue_ready = (cnt != CMAX);
  assign cnt_zero       = (cnt == '0);
  assign inc            = ld_issue_valid && ld_issue_ready;
  assign dec            = ld_ret_valid && !cnt_zero;

  for (genvar k = 0; k < NKILL; k++) begin : g_kill
    assign hit_ret[k] = kill_v[k] && (kill_reg[k*RW +: RW] == ld_ret_reg);
    assign hit_cur[k] = kill_v[k] && (kill_reg[k*RW +: RW] == ll_reg);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   cnt <= cnt + ONE;
        2'b01:   cnt <= cnt - ONE;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ll_valid <= 1'b0;
      ll_reg   <= '0;
    end else if (ld_ret_valid) begin
      ll_reg   <= ld_ret_reg;
      ll_valid <= ~|hit_ret;
    end else if (|hit_cur) begin
      ll_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
  import fwd_pkg::*;
#(
  parameter int RW = 4
) (
  input  logic          use_op,
  input  logic [RW-1:0] src,
  input  logic [1:0]    cls,
  input  logic          lr_en,
  input  logic          lr_valid,
  input  logic [RW-1:0] lr_dest,
  input  logic          ll_en,
  input  logic          ll_valid,
  input  logic [RW-1:0] ll_reg,
  input  logic          cnt_zero,
  output logic [1:0]    sel,
  output logic          stall
);

  src_sel_e pick;
  logic     lr_hit, ll_hit;

  always_comb begin
    lr_hit = lr_en && lr_valid && (src == lr_dest);
    ll_hit = ll_en && ll_valid && (src == ll_reg);
    pick   = SRC_RF;
    stall  = 1'b0;
    if (use_op && class_can_forward(cls)) begin
      if (lr_hit) begin
        pick = SRC_LR;
      end else if (ll_hit) begin
        if (cnt_zero) pick = SRC_LL;
        else          stall = 1'b1;
      end
    end
    sel = pick;
  end

endmodule

// File: rtl/fwd_ctrl.sv
module fwd_ctrl
  import fwd_pkg::*;
#(
  parameter int RW   = 4,
  parameter int NOPS = 2,
  parameter int CW   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_lr_en,
  input  logic              cfg_ll_en,
  input  logic              dec_valid,
  output logic              dec_ready,
  input  logic [1:0]        dec_cls,
  input  logic [3:0]        dec_cond,
  input  logic              dec_wr,
  input  logic [RW-1:0]     dec_dst,
  input  logic [NOPS*RW-1:0] dec_src,
  input  logic [NOPS-1:0]   dec_src_use,
  output logic [2*NOPS-1:0] op_sel,
  output logic [NOPS-1:0]   op_stall,
  input  logic              ld_issue_valid,
  output logic              ld_issue_ready,
  input  logic              ld_ret_valid,
  input  logic [RW-1:0]     ld_ret_reg,
  input  logic              alu_wb_valid,
  input  logic [RW-1:0]     alu_wb_reg
);

  localparam int NKILL = 2;

  logic          acc;
  logic          lr_valid, ll_valid, cnt_zero;
  logic [RW-1:0] lr_dest, ll_reg;
  logic [CW-1:0] ll_cnt;
  logic [NKILL-1:0]    kill_v;
  logic [NKILL*RW-1:0] kill_reg;

  assign dec_ready = ~|op_stall;
  assign acc       = dec_valid && dec_ready;

  assign kill_v   = {alu_wb_valid, acc && dec_wr && (dec_cls != CLS_LOAD)};
  assign kill_reg = {alu_wb_reg, dec_dst};

  fwd_lr_track #(.RW(RW)) u_lr (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc      (acc),
    .cls      (dec_cls),
    .cond     (dec_cond),
    .wr       (dec_wr),
    .dst      (dec_dst),
    .lr_valid (lr_valid),
    .lr_dest  (lr_dest)
  );

  fwd_ll_track #(.RW(RW), .CW(CW), .NKILL(NKILL)) u_ll (
    .clk            (clk),
    .rst_n          (rst_n),
    .ld_issue_valid (ld_issue_valid),
    .ld_issue_ready (ld_issue_ready),
    .ld_ret_valid   (ld_ret_valid),
    .ld_ret_reg     (ld_ret_reg),
    .kill_v         (kill_v),
    .kill_reg       (kill_reg),
    .ll_valid       (ll_valid),
    .ll_reg         (ll_reg),
    .cnt_zero       (cnt_zero),
    .cnt            (ll_cnt)
  );

  for (genvar k = 0; k < NOPS; k++) begin : g_op
    fwd_operand_sel #(.RW(RW)) u_sel (
      .use_op   (dec_src_use[k]),
      .src      (dec_src[k*RW +: RW]),
      .cls      (dec_cls),
      .lr_en    (cfg_lr_en),
      .lr_valid (lr_valid),
      .lr_dest  (lr_dest),
      .ll_en    (cfg_ll_en),
      .ll_valid (ll_valid),
      .ll_reg   (ll_reg),
      .cnt_zero (cnt_zero),
      .sel      (op_sel[2*k +: 2]),
      .stall    (op_stall[k])
    );
  end

endmodule

// File: rtl/fwd_ctrl_checker.sv
module fwd_ctrl_checker #(
  parameter int NOPS = 2,
  parameter int CW   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_lr_en,
  input logic              cfg_ll_en,
  input logic [1:0]        dec_cls,
  input logic [NOPS-1:0]   dec_src_use,
  input logic [2*NOPS-1:0] op_sel,
  input logic [NOPS-1:0]   op_stall,
  input logic              ld_issue_valid,
  input logic              ld_ret_valid,
  input logic [CW-1:0]     ll_cnt
);

  localparam logic [CW-1:0] CMAX = '1;

  logic [NOPS-1:0] is_lr, is_ll;
  for (genvar k = 0; k < NOPS; k++) begin : g_dec
    assign is_lr[k] = (op_sel[2*k +: 2] == 2'd1);
    assign is_ll[k] = (op_sel[2*k +: 2] == 2'd2);

    a_r4_unused_rf: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_src_use[k] |-> (op_sel[2*k +: 2] == 2'd0) && !op_stall[k]);
  end

  a_r9_lr_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_lr_en |-> (is_lr == '0));

  a_r9_ll_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ll_en |-> (is_ll == '0) && (op_stall == '0));

  a_r4_class_no_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    dec_cls[1] |-> (op_sel == '0) && (op_stall == '0));

  a_r6_stall_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (|op_stall) |-> (ll_cnt != '0));

  a_r5_ll_when_drained: assert property (@(posedge clk) disable iff (!rst_n)
    (|is_ll) |-> (ll_cnt == '0));

  a_r8_no_wrap_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ll_cnt == CMAX) |=> (ll_cnt >= CMAX - 1));

  a_r8_no_wrap_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ll_cnt == '0) && !ld_issue_valid |=> (ll_cnt == '0));

endmodule

bind fwd_ctrl fwd_ctrl_checker #(.NOPS(NOPS), .CW(CW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_lr_en      (cfg_lr_en),
  .cfg_ll_en      (cfg_ll_en),
  .dec_cls        (dec_cls),
  .dec_src_use    (dec_src_use),
  .op_sel         (op_sel),
  .op_stall       (op_stall),
  .ld_issue_valid (ld_issue_valid),
  .ld_ret_valid   (ld_ret_valid),
  .ll_cnt         (ll_cnt)
);

// File: tb/tb_fwd_ctrl.sv
module tb_fwd_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_lr_en = 1'b1, cfg_ll_en = 1'b1;
  logic       dec_valid = 1'b0;
  logic       dec_ready;
  logic [1:0] dec_cls = 2'd0;
  logic [3:0] dec_cond = 4'hE;
  logic       dec_wr = 1'b0;
  logic [3:0] dec_dst = 4'd0;
  logic [7:0] dec_src = 8'd0;
  logic [1:0] dec_src_use = 2'b00;
  logic [3:0] op_sel;
  logic [1:0] op_stall;
  logic       ld_issue_valid = 1'b0, ld_issue_ready;
  logic       ld_ret_valid = 1'b0;
  logic [3:0] ld_ret_reg = 4'd0;
  logic       alu_wb_valid = 1'b0;
  logic [3:0] alu_wb_reg = 4'd0;

  int n_run = 0, n_fail = 0;

  // reference state built from the requirements
  bit m_lr_v = 0; int m_lr_d = 0;
  bit m_ll_v = 0; int m_ll_r = 0;
  int m_cnt = 0;

  always #5 clk = ~clk;

  fwd_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_lr_en(cfg_lr_en), .cfg_ll_en(cfg_ll_en),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_cls(dec_cls),
    .dec_cond(dec_cond), .dec_wr(dec_wr), .dec_dst(dec_dst), .dec_src(dec_src),
    .dec_src_use(dec_src_use), .op_sel(op_sel), .op_stall(op_stall),
    .ld_issue_valid(ld_issue_valid), .ld_issue_ready(ld_issue_ready),
    .ld_ret_valid(ld_ret_valid), .ld_ret_reg(ld_ret_reg),
    .alu_wb_valid(alu_wb_valid), .alu_wb_reg(alu_wb_reg)
  );

  task automatic check(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect_op(int r, bit u, output int sel, output int st);
    sel = 0; st = 0;
    if (u && dec_cls < 2) begin
      if (cfg_lr_en && m_lr_v && r == m_lr_d) sel = 1;
      else if (cfg_ll_en && m_ll_v && r == m_ll_r) begin
        if (m_cnt == 0) sel = 2; else st = 1;
      end
    end
  endtask

  task automatic set_ins(int cls, int cond, bit wr, int dst, int a, bit au, int b, bit bu);
    dec_valid = 1'b1; dec_cls = 2'(cls); dec_cond = 4'(cond); dec_wr = wr;
    dec_dst = 4'(dst); dec_src = {4'(b), 4'(a)}; dec_src_use = {bu, au};
  endtask

  // one cycle: compare outputs at negedge, update the reference after posedge
  task automatic cyc(string req);
    int sa, ta, sb, tb_, rdy;
    bit acc, kd, kw, inc, dcr;
    @(negedge clk);
    expect_op(int'(dec_src[3:0]), dec_src_use[0], sa, ta);
    expect_op(int'(dec_src[7:4]), dec_src_use[1], sb, tb_);
    rdy = (ta == 0 && tb_ == 0);
    check(req, "op0 sel", int'(op_sel[1:0]), sa);
    check(req, "op1 sel", int'(op_sel[3:2]), sb);
    check(req, "stall", int'(op_stall), tb_ * 2 + ta);
    check(req, "dec_ready", int'(dec_ready), rdy);
    check(req, "ld_issue_ready", int'(ld_issue_ready), int'(m_cnt != 7));
    acc = dec_valid && rdy;
    kd  = acc && dec_wr && dec_cls != 2'd1;
    kw  = alu_wb_valid;
    inc = ld_issue_valid && m_cnt != 7;
    dcr = ld_ret_valid && m_cnt != 0;
    @(posedge clk);
    if (ld_ret_valid) begin
      m_ll_r = int'(ld_ret_reg);
      m_ll_v = !((kd && dec_dst == ld_ret_reg) || (kw && alu_wb_reg == ld_ret_reg));
    end else if ((kd && int'(dec_dst) == m_ll_r) || (kw && int'(alu_wb_reg) == m_ll_r))
      m_ll_v = 0;
    if (acc) begin
      m_lr_v = dec_wr && dec_cls == 2'd0 && dec_cond == 4'hE;
      m_lr_d = int'(dec_dst);
    end
    m_cnt = m_cnt + int'(inc) - int'(dcr);
    #1;
    dec_valid = 1'b0; ld_issue_valid = 1'b0; ld_ret_valid = 1'b0; alu_wb_valid = 1'b0;
  endtask

  task automatic idle(string req);
    dec_valid = 1'b0;
    cyc(req);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    // R11: reset state, consumer of every register sees the register file
    for (int r = 0; r < 16; r++) begin
      set_ins(0, 4'hE, 0, 0, r, 1, r, 1);
      cyc("R11");
    end

    // R1 / R2: full sweep of producer destination against consumer operands
    for (int p = 0; p < 16; p++) begin
      for (int s = 0; s < 16; s++) begin
        set_ins(0, 4'hE, 1, p, 15 - p, 1, 15 - p, 0);
        cyc("R1");
        set_ins(s[0], 4'hE, 0, 0, s, 1, p, 1);
        cyc("R1");
      end
    end

    // R3: every condition code, plus non-writing and non-DP producers
    for (int c = 0; c < 16; c++) begin
      set_ins(0, c, 1, 7, 0, 0, 0, 0); cyc("R3");
      set_ins(0, 4'hE, 0, 0, 7, 1, 7, 1); cyc("R3");
    end
    set_ins(0, 4'hE, 0, 6, 0, 0, 0, 0); cyc("R3");
    set_ins(0, 4'hE, 0, 0, 6, 1, 0, 0); cyc("R3");
    set_ins(3, 4'hE, 1, 6, 0, 0, 0, 0); cyc("R3");
    set_ins(0, 4'hE, 0, 0, 6, 1, 0, 0); cyc("R3");

    // R2: idle cycles keep the last result; a second instruction ends it
    set_ins(0, 4'hE, 1, 9, 0, 0, 0, 0); cyc("R2");
    idle("R2"); idle("R2");
    set_ins(0, 4'hE, 0, 0, 9, 1, 0, 0); cyc("R2");
    set_ins(0, 4'hE, 0, 0, 9, 1, 9, 1); cyc("R2");

    // R4: store/other classes and unused operands
    set_ins(0, 4'hE, 1, 4, 0, 0, 0, 0); cyc("R4");
    set_ins(2, 4'hE, 0, 0, 4, 1, 4, 1); cyc("R4");
    set_ins(0, 4'hE, 1, 4, 0, 0, 0, 0); cyc("R4");
    set_ins(0, 4'hE, 0, 0, 4, 0, 4, 1); cyc("R4");

    // R5 / R6: three loads in flight, consumer of the returned register
    ld_issue_valid = 1; cyc("R8");
    ld_issue_valid = 1; cyc("R8");
    ld_issue_valid = 1; cyc("R8");
    ld_ret_valid = 1; ld_ret_reg = 4'd3; cyc("R5");
    set_ins(0, 4'hE, 0, 0, 3, 1, 0, 0); cyc("R6");
    set_ins(0, 4'hE, 0, 0, 3, 1, 0, 0); ld_ret_valid = 1; ld_ret_reg = 4'd5; cyc("R6");
    set_ins(1, 4'hE, 0, 0, 1, 0, 5, 1); cyc("R6");
    set_ins(1, 4'hE, 0, 0, 1, 0, 5, 1); ld_ret_valid = 1; ld_ret_reg = 4'd5; cyc("R6");
    for (int i = 0; i < 5; i++) begin
      set_ins(i % 2, 4'hE, 0, 0, 5, 1, 2, 1); cyc("R5");
    end
    set_ins(0, 4'hE, 0, 0, 5, 0, 5, 1); ld_issue_valid = 1; cyc("R6");
    set_ins(0, 4'hE, 0, 0, 5, 0, 5, 1); cyc("R6");

    // R8: issue and return together, then fill to saturation
    ld_issue_valid = 1; ld_ret_valid = 1; ld_ret_reg = 4'd5; cyc("R8");
    ld_ret_valid = 1; ld_ret_reg = 4'd5; cyc("R8");
    ld_ret_valid = 1; ld_ret_reg = 4'd5; cyc("R8");
    for (int i = 0; i < 9; i++) begin
      ld_issue_valid = 1; cyc("R8");
    end
    ld_issue_valid = 1; ld_ret_valid = 1; ld_ret_reg = 4'd8; cyc("R8");
    for (int i = 0; i < 7; i++) begin
      ld_ret_valid = 1; ld_ret_reg = 4'd8; cyc("R8");
    end
    set_ins(0, 4'hE, 0, 0, 8, 1, 0, 0); cyc("R8");

    // R7: decode kill, write-back kill, kill racing a return
    set_ins(0, 4'hE, 0, 0, 8, 1, 8, 1); cyc("R7");
    set_ins(0, 4'h1, 1, 8, 0, 0, 0, 0); cyc("R7");
    set_ins(3, 4'hE, 0, 0, 0, 0, 0, 0); cyc("R7");
    set_ins(0, 4'hE, 0, 0, 8, 1, 0, 0); cyc("R7");
    ld_ret_valid = 1; ld_ret_reg = 4'd10; cyc("R7");
    alu_wb_valid = 1; alu_wb_reg = 4'd11; cyc("R7");
    set_ins(0, 4'hE, 0, 0, 10, 1, 0, 0); cyc("R7");
    alu_wb_valid = 1; alu_wb_reg = 4'd10; cyc("R7");
    set_ins(0, 4'hE, 0, 0, 10, 1, 0, 0); cyc("R7");
    ld_ret_valid = 1; ld_ret_reg = 4'd12; alu_wb_valid = 1; alu_wb_reg = 4'd12; cyc("R7");
    set_ins(0, 4'hE, 0, 0, 12, 1, 0, 0); cyc("R7");
    set_ins(1, 4'hE, 1, 13, 0, 0, 0, 0); ld_ret_valid = 1; ld_ret_reg = 4'd13; cyc("R7");
    set_ins(2, 4'hE, 0, 0, 0, 0, 0, 0); cyc("R7");
    set_ins(0, 4'hE, 0, 0, 13, 1, 0, 0); cyc("R7");

    // R10: both latches valid for the same register
    set_ins(0, 4'hE, 1, 14, 0, 0, 0, 0); cyc("R10");
    ld_ret_valid = 1; ld_ret_reg = 4'd14; cyc("R10");
    set_ins(0, 4'hE, 0, 0, 14, 1, 14, 1); cyc("R10");
    set_ins(0, 4'hE, 0, 0, 14, 1, 0, 0); cyc("R10");

    // R9: each path disabled on its own
    cfg_lr_en = 0;
    set_ins(0, 4'hE, 1, 2, 0, 0, 0, 0); cyc("R9");
    set_ins(0, 4'hE, 0, 0, 2, 1, 14, 1); cyc("R9");
    cfg_lr_en = 1; cfg_ll_en = 0;
    ld_issue_valid = 1; cyc("R9");
    set_ins(0, 4'hE, 0, 0, 14, 1, 14, 1); cyc("R9");
    ld_ret_valid = 1; ld_ret_reg = 4'd1; cyc("R9");
    set_ins(0, 4'hE, 0, 0, 1, 1, 0, 0); cyc("R9");
    cfg_ll_en = 1;
    set_ins(0, 4'hE, 0, 0, 1, 1, 0, 0); cyc("R9");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule